// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block holds the architectural-to-physical register mappings of an out-of-order core for three register classes: integer, floating point and condition code. Each class has its own table. A fourth class, miscellaneous registers, owns no table: its physical index is a fixed offset from its class-relative number. Every request carries one unified architectural index. The block sorts that index into a class and a class-relative number, and steers the request to the matching table.

The request port takes three commands. A rename draws the head register of the target class's free list and answers with the newly assigned register and the one it replaces. A set-entry overwrites one slot, so that older mappings can be restored after a squash. A no-op does nothing. A separate lookup port reads the current mapping combinationally. The free lists are first-in first-out queues kept outside the block: each queue offers a non-empty flag and a head value, and the block pulses a pop line when it consumes the head. The block also reports the smaller of the integer and floating-point free counts. That value is the number of allocations the core can count on, whichever of those two classes it asks for.

Top module: `rename_table_unified`

## Requirements
- R1: After reset, architectural register i of the integer, floating-point and condition-code classes maps to physical register base+i. The bases are 0, INT_PHYS and INT_PHYS+FP_PHYS.
- R2: The lookup port returns the current mapping of `lk_arch` in the same cycle. A lookup changes no state.
- R3: A rename (`op_code`=2'b01) of an ordinary register whose class free list is non-empty does the following in the same cycle: it sets `rsp_ok`, drives the free-list head on `rsp_new` and the old mapping on `rsp_prev`, and raises only that class's bit of `fl_pop` (bit 0 integer, bit 1 floating point, bit 2 condition code). The slot holds the new register from the next cycle on.
- R4: The zero register of a class is read-only. A rename of it sets `rsp_ok` and returns its current mapping as both `rsp_new` and `rsp_prev`, without popping. A set-entry to it is ignored. A class has no zero register when its zero index equals its class size, and by default only integer register 0 is one.
- R5: A miscellaneous register is not renamed. Its lookup and rename both return relative index + total physical registers. A rename of it reports that value as both new and previous, with `rsp_ok` set, and it neither pops nor stalls.
- R6: A rename of an ordinary register whose free list is empty raises `rename_stall`. It clears `rsp_ok`, pops nothing and leaves the map unchanged.
- R7: A set-entry (`op_code`=2'b10) writes `op_set_phys` into the addressed slot, and the new value is visible from the next cycle. A set-entry to a miscellaneous register has no effect.
- R8: `free_min` always equals the minimum of `int_free_cnt` and `fp_free_cnt`. The condition-code count plays no part.
- R9: The unified index is decoded by range. Integer registers take [0,INT_ARCH), floating-point registers the next FP_ARCH indices, condition-code registers the next CC_ARCH, and miscellaneous registers the rest. Codes 2'b00 and 2'b11 are no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 2 | Command: 00 none, 01 rename, 10 set-entry, 11 none |
| op_arch | input | AW | Unified architectural index of the command |
| op_set_phys | input | PW | Physical register written by set-entry |
| rsp_ok | output | 1 | Rename completed this cycle |
| rsp_new | output | PW | Newly assigned physical register |
| rsp_prev | output | PW | Previous physical register |
| rename_stall | output | 1 | Rename refused: free list empty |
| lk_arch | input | AW | Unified architectural index to look up |
| lk_phys | output | PW | Current physical register of `lk_arch` |
| fl_avail | input | 3 | Per-class free list non-empty (int, fp, cc) |
| fl_head | input | 3*PW | Per-class free-list head, class c at bits c*PW upward |
| fl_pop | output | 3 | Per-class pop of the free-list head |
| int_free_cnt | input | CW | Integer free-list occupancy |
| fp_free_cnt | input | CW | Floating-point free-list occupancy |
| free_min | output | CW | Minimum of the two counts |

## Verification
The hardest state to reach from the ports is an empty free list that meets a rename while the other classes still have free registers. Random traffic with immediate recycling of the previous register never drains a list. A directed phase therefore renames condition-code registers back to back with recycling off until the list runs dry, and then tries once more. The random phase that follows runs from a fresh reset. It recycles every replaced register into the harness queue, so rename, set-entry, zero-register and miscellaneous traffic mix over long stretches. Each lookup is compared with the bench's own map model.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FP   = 2'd1,
    RC_CC   = 2'd2,
    RC_MISC = 2'd3
  } rclass_e;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_RENAME = 2'b01,
    OP_SET    = 2'b10,
    OP_HOLD   = 2'b11
  } rop_e;

  // Class of a unified index, decided by consecutive ranges.
  function automatic rclass_e class_of(input int unsigned idx, input int unsigned ni,
                                       input int unsigned nf, input int unsigned nc);
    if (idx < ni) return RC_INT;
    if (idx < ni + nf) return RC_FP;
    if (idx < ni + nf + nc) return RC_CC;
    return RC_MISC;
  endfunction

  // Index relative to the first register of its class.
  function automatic int unsigned rel_of(input int unsigned idx, input int unsigned ni,
                                         input int unsigned nf, input int unsigned nc);
    if (idx < ni) return idx;
    if (idx < ni + nf) return idx - ni;
    if (idx < ni + nf + nc) return idx - ni - nf;
    return idx - ni - nf - nc;
  endfunction

  // Fixed physical number given to a miscellaneous register.
  function automatic int unsigned misc_phys(input int unsigned rel, input int unsigned total);
    return rel + total;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rn_decode.sv
module rn_decode
  import rn_pkg::*;
#(
  parameter int NI = 8,
  parameter int NF = 8,
  parameter int NC = 4,
  parameter int AW = 5,
  parameter int RW = 4
) (
  input  logic [AW-1:0] idx,
  output rclass_e       cls,
  output logic [RW-1:0] rel
);
  int unsigned u;

  assign u   = 32'(idx);
  assign cls = class_of(u, NI, NF, NC);
  assign rel = RW'(rel_of(u, NI, NF, NC));
endmodule

// File: rtl/rn_map_bank.sv
module rn_map_bank #(
  parameter int N_ARCH = 8,
  parameter int RW     = 4,
  parameter int PW     = 6,
  parameter int BASE   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ra_idx,
  output logic [PW-1:0] ra_phys,
  input  logic [RW-1:0] rb_idx,
  output logic [PW-1:0] rb_phys,
  input  logic          we,
  input  logic [RW-1:0] w_idx,
  input  logic [PW-1:0] w_phys
);
  localparam int IW = (N_ARCH > 1) ? $clog2(N_ARCH) : 1;

  logic [PW-1:0] tbl [N_ARCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ARCH; i++) tbl[i] <= PW'(BASE + i);
    end else if (we && (32'(w_idx) < N_ARCH)) begin
      tbl[w_idx[IW-1:0]] <= w_phys;
    end
  end

  assign ra_phys = (32'(ra_idx) < N_ARCH) ? tbl[ra_idx[IW-1:0]] : '0;
  assign rb_phys = (32'(rb_idx) < N_ARCH) ? tbl[rb_idx[IW-1:0]] : '0;
endmodule

// File: rtl/rn_min_sel.sv
module rn_min_sel #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic [CW-1:0] y
);
  assign y = (a < b) ? a : b;
endmodule

// File: rtl/rename_table_unified.sv
module rename_table_unified
  import rn_pkg::*;
#(
  parameter int INT_ARCH  = 8,
  parameter int FP_ARCH   = 8,
  parameter int CC_ARCH   = 4,
  parameter int MISC_ARCH = 4,
  parameter int INT_PHYS  = 16,
  parameter int FP_PHYS   = 16,
  parameter int CC_PHYS   = 8,
  parameter int INT_ZERO  = 0,
  parameter int FP_ZERO   = FP_ARCH,
  parameter int CC_ZERO   = CC_ARCH,
  localparam int ARCH_TOT = INT_ARCH + FP_ARCH + CC_ARCH + MISC_ARCH,
  localparam int PHYS_TOT = INT_PHYS + FP_PHYS + CC_PHYS,
  localparam int AW       = $clog2(ARCH_TOT),
  localparam int PW       = $clog2(PHYS_TOT + MISC_ARCH),
  localparam int MAXA     = int'(max2(max2(INT_ARCH, FP_ARCH), max2(CC_ARCH, MISC_ARCH))),
  localparam int RW       = $clog2(MAXA + 1),
  localparam int CW       = $clog2(int'(max2(INT_PHYS, FP_PHYS)) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_code,
  input  logic [AW-1:0]   op_arch,
  input  logic [PW-1:0]   op_set_phys,
  output logic            rsp_ok,
  output logic [PW-1:0]   rsp_new,
  output logic [PW-1:0]   rsp_prev,
  output logic            rename_stall,
  input  logic [AW-1:0]   lk_arch,
  output logic [PW-1:0]   lk_phys,
  input  logic [2:0]      fl_avail,
  input  logic [3*PW-1:0] fl_head,
  output logic [2:0]      fl_pop,
  input  logic [CW-1:0]   int_free_cnt,
  input  logic [CW-1:0]   fp_free_cnt,
  output logic [CW-1:0]   free_min
);

  function automatic int unsigned zero_of(input int c);
    case (c)
      0:       return INT_ZERO;
      1:       return FP_ZERO;
      default: return CC_ZERO;
    endcase
  endfunction

  function automatic int class_arch(input int c);
    case (c)
      0:       return INT_ARCH;
      1:       return FP_ARCH;
      default: return CC_ARCH;
    endcase
  endfunction

  function automatic int class_base(input int c);
    case (c)
      0:       return 0;
      1:       return INT_PHYS;
      default: return INT_PHYS + FP_PHYS;
    endcase
  endfunction

  rop_e          op;
  rclass_e       op_cls, lk_cls;
  logic [RW-1:0] op_rel, lk_rel;
  logic [PW-1:0] rd_a [3];
  logic [PW-1:0] rd_b [3];
  logic [2:0]    wr_en;
  logic [PW-1:0] wr_phys;

  logic [PW-1:0] cur_map, head, op_misc, lk_map;
  logic          avail, zero_hit, is_ren, is_set, is_misc;

  // Named internal events, observed by the bound checker.
  logic ev_alloc, ev_zero_hit, ev_misc, ev_stall, ev_restore;

  assign op = rop_e'(op_code);

  rn_decode #(.NI(INT_ARCH), .NF(FP_ARCH), .NC(CC_ARCH), .AW(AW), .RW(RW)) u_dec_op (
    .idx(op_arch), .cls(op_cls), .rel(op_rel)
  );

  rn_decode #(.NI(INT_ARCH), .NF(FP_ARCH), .NC(CC_ARCH), .AW(AW), .RW(RW)) u_dec_lk (
    .idx(lk_arch), .cls(lk_cls), .rel(lk_rel)
  );

  for (genvar c = 0; c < 3; c++) begin : g_bank
    rn_map_bank #(
      .N_ARCH(class_arch(c)), .RW(RW), .PW(PW), .BASE(class_base(c))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (op_rel),
      .ra_phys(rd_a[c]),
      .rb_idx (lk_rel),
      .rb_phys(rd_b[c]),
      .we     (wr_en[c]),
      .w_idx  (op_rel),
      .w_phys (wr_phys)
    );
  end

  // Route the class-specific state to the request.
  always_comb begin
    cur_map  = '0;
    head     = '0;
    avail    = 1'b0;
    zero_hit = 1'b0;
    lk_map   = '0;
    for (int c = 0; c < 3; c++) begin
      if (op_cls == rclass_e'(2'(c))) begin
        cur_map  = rd_a[c];
        head     = fl_head[c*PW +: PW];
        avail    = fl_avail[c];
        zero_hit = (32'(op_rel) == zero_of(c));
      end
      if (lk_cls == rclass_e'(2'(c))) lk_map = rd_b[c];
    end
  end

  assign op_misc = PW'(misc_phys(32'(op_rel), PHYS_TOT));
  assign is_ren  = (op == OP_RENAME);
  assign is_set  = (op == OP_SET);
  assign is_misc = (op_cls == RC_MISC);

  assign ev_misc     = is_ren & is_misc;
  assign ev_zero_hit = is_ren & ~is_misc & zero_hit;
  assign ev_stall    = is_ren & ~is_misc & ~zero_hit & ~avail;
  assign ev_alloc    = is_ren & ~is_misc & ~zero_hit & avail;
  assign ev_restore  = is_set & ~is_misc & ~zero_hit;

  assign rsp_ok       = ev_alloc | ev_zero_hit | ev_misc;
  assign rename_stall = ev_stall;
  assign rsp_new      = ev_misc ? op_misc : (ev_alloc ? head : cur_map);
  assign rsp_prev     = ev_misc ? op_misc : cur_map;
  assign wr_phys      = ev_alloc ? head : op_set_phys;

  for (genvar c = 0; c < 3; c++) begin : g_ctl
    assign fl_pop[c] = ev_alloc & (op_cls == rclass_e'(2'(c)));
    assign wr_en[c]  = (ev_alloc | ev_restore) & (op_cls == rclass_e'(2'(c)));
  end

  assign lk_phys = (lk_cls == RC_MISC) ? PW'(misc_phys(32'(lk_rel), PHYS_TOT)) : lk_map;

  rn_min_sel #(.CW(CW)) u_min (
    .a(int_free_cnt), .b(fp_free_cnt), .y(free_min)
  );

endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
  parameter int PHYS_TOT = 40,
  parameter int AW       = 5,
  parameter int PW       = 6,
  parameter int CW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    op_code,
  input logic [AW-1:0] op_arch,
  input logic          rsp_ok,
  input logic [PW-1:0] rsp_new,
  input logic [PW-1:0] rsp_prev,
  input logic          rename_stall,
  input logic [AW-1:0] lk_arch,
  input logic [PW-1:0] lk_phys,
  input logic [2:0]    fl_pop,
  input logic [CW-1:0] int_free_cnt,
  input logic [CW-1:0] fp_free_cnt,
  input logic [CW-1:0] free_min,
  input logic          ev_alloc,
  input logic          ev_zero_hit,
  input logic          ev_misc
);

  // R6
  stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rename_stall |-> (fl_pop == 3'b000) && !rsp_ok);

  // R6
  stall_only_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rename_stall |-> (op_code == 2'b01));

  // R3
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_pop));

  // R3
  alloc_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |-> ($countones(fl_pop) == 1) && rsp_ok);

  // R3
  alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> (lk_arch != $past(op_arch)) || (lk_phys == $past(rsp_new)));

  // R4
  zero_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero_hit |-> (fl_pop == 3'b000) && (rsp_new == rsp_prev) && rsp_ok);

  // R5
  misc_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_misc |-> (rsp_new == rsp_prev) && (32'(rsp_new) >= PHYS_TOT) && (fl_pop == 3'b000));

  // R8
  free_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_min <= int_free_cnt) && (free_min <= fp_free_cnt) &&
    ((free_min == int_free_cnt) || (free_min == fp_free_cnt)));

endmodule

bind rename_table_unified rn_checker #(
  .PHYS_TOT(PHYS_TOT), .AW(AW), .PW(PW), .CW(CW)
) u_rn_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_code     (op_code),
  .op_arch     (op_arch),
  .rsp_ok      (rsp_ok),
  .rsp_new     (rsp_new),
  .rsp_prev    (rsp_prev),
  .rename_stall(rename_stall),
  .lk_arch     (lk_arch),
  .lk_phys     (lk_phys),
  .fl_pop      (fl_pop),
  .int_free_cnt(int_free_cnt),
  .fp_free_cnt (fp_free_cnt),
  .free_min    (free_min),
  .ev_alloc    (ev_alloc),
  .ev_zero_hit (ev_zero_hit),
  .ev_misc     (ev_misc)
);

// File: tb/rename_table_unified_tb.sv
`timescale 1ns/1ps
module rename_table_unified_tb;
  localparam int AW = 5, PW = 6, CW = 5;
  localparam int NARCH = 24, TOT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic [AW-1:0] op_arch = '0, lk_arch = '0;
  logic [PW-1:0] op_set_phys = '0;
  logic rsp_ok, rename_stall;
  logic [PW-1:0] rsp_new, rsp_prev, lk_phys;
  logic [2:0] fl_avail, fl_pop;
  logic [3*PW-1:0] fl_head;
  logic [CW-1:0] int_free_cnt, fp_free_cnt, free_min;

  int n_chk = 0, n_fail = 0;
  int mdl [NARCH];
  logic [PW-1:0] fq [3][16];
  int fh [3];
  int fcnt [3];

  always #4 clk = ~clk;

  rename_table_unified u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_arch(op_arch),
    .op_set_phys(op_set_phys), .rsp_ok(rsp_ok), .rsp_new(rsp_new),
    .rsp_prev(rsp_prev), .rename_stall(rename_stall), .lk_arch(lk_arch),
    .lk_phys(lk_phys), .fl_avail(fl_avail), .fl_head(fl_head), .fl_pop(fl_pop),
    .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt), .free_min(free_min)
  );

  // Harness free lists
  always_comb begin
    for (int c = 0; c < 3; c++) begin
      fl_avail[c] = (fcnt[c] > 0);
      fl_head[c*PW +: PW] = fq[c][fh[c]];
    end
    int_free_cnt = CW'(fcnt[0]);
    fp_free_cnt  = CW'(fcnt[1]);
  end

  function automatic int bcls(input int a);
    return (a < 8) ? 0 : (a < 16) ? 1 : (a < 20) ? 2 : 3;
  endfunction
  function automatic int bstart(input int c);
    return c * 8 + ((c == 3) ? -4 : 0);
  endfunction
  function automatic int brel(input int a);
    return a - bstart(bcls(a));
  endfunction
  function automatic int bbase(input int c);
    return c * 16;
  endfunction
  function automatic int bphys(input int c);
    return (c == 2) ? 8 : 16;
  endfunction
  function automatic bit bzero(input int a);
    return a == 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_code = 2'b00;
    for (int a = 0; a < 20; a++) mdl[a] = bbase(bcls(a)) + brel(a);
    for (int c = 0; c < 3; c++) begin
      int na = (c == 2) ? 4 : 8;
      fh[c] = 0;
      fcnt[c] = bphys(c) - na;
      for (int k = 0; k < 16; k++) fq[c][k] = PW'(bbase(c) + na + k);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(input logic [1:0] op, input int a, input int sp, input int la,
                       input bit recycle);
    int c, exp_lk, exp_new, exp_prev, exp_pop;
    bit exp_ok, exp_stall, alloc, wr;
    @(negedge clk);
    op_code = op; op_arch = AW'(a); op_set_phys = PW'(sp); lk_arch = AW'(la);
    #1;
    c = bcls(a);
    exp_lk = (bcls(la) == 3) ? brel(la) + TOT : mdl[la];
    if (bcls(la) == 3) chk(lk_phys == PW'(exp_lk), "R5 misc lookup", lk_phys, exp_lk);
    else chk(lk_phys == PW'(exp_lk), "R2 lookup", lk_phys, exp_lk);
    chk(free_min == CW'((fcnt[0] < fcnt[1]) ? fcnt[0] : fcnt[1]), "R8 free_min", free_min,
        (fcnt[0] < fcnt[1]) ? fcnt[0] : fcnt[1]);
    exp_ok = 0; exp_stall = 0; exp_pop = 0; alloc = 0; wr = 0;
    exp_new = 0; exp_prev = 0;
    if (op == 2'b01) begin
      if (c == 3) begin
        exp_ok = 1; exp_new = brel(a) + TOT; exp_prev = exp_new;
        chk(rsp_new == PW'(exp_new) && rsp_prev == PW'(exp_prev), "R5 misc rename",
            rsp_new, exp_new);
      end else if (bzero(a)) begin
        exp_ok = 1; exp_new = mdl[a]; exp_prev = mdl[a];
        chk(rsp_new == PW'(exp_new) && rsp_prev == PW'(exp_prev), "R4 zero rename",
            rsp_new, exp_new);
      end else if (fcnt[c] == 0) begin
        exp_stall = 1;
      end else begin
        exp_ok = 1; alloc = 1; exp_pop = 1 << c;
        exp_new = fq[c][fh[c]]; exp_prev = mdl[a];
        chk(rsp_new == PW'(exp_new), "R3 new", rsp_new, exp_new);
        chk(rsp_prev == PW'(exp_prev), "R3 prev", rsp_prev, exp_prev);
      end
    end else if (op == 2'b10) begin
      wr = (c != 3) && !bzero(a);
    end
    chk(rsp_ok == exp_ok, "R3 rsp_ok", rsp_ok, exp_ok);
    chk(rename_stall == exp_stall, "R6 stall", rename_stall, exp_stall);
    chk(fl_pop == 3'(exp_pop), "R3 pop", fl_pop, exp_pop);
    @(posedge clk);
    #1;
    if (alloc) begin
      mdl[a] = exp_new;
      fh[c] = (fh[c] + 1) % 16;
      fcnt[c]--;
      if (recycle) begin
        fq[c][(fh[c] + fcnt[c]) % 16] = PW'(exp_prev);
        fcnt[c]++;
      end
    end
    if (wr) mdl[a] = sp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 R9: reset identity map and range decode, closed form
    for (int a = 0; a < NARCH; a++) begin
      int e;
      @(negedge clk);
      lk_arch = AW'(a);
      #1;
      e = (a < 8) ? a : (a < 16) ? 16 + a - 8 : (a < 20) ? 32 + a - 16 : 40 + a - 20;
      chk(lk_phys == PW'(e), "R1 R9 reset map", lk_phys, e);
    end
    // R3: int rename, then lookup
    do_op(2'b01, 3, 0, 3, 0);
    do_op(2'b00, 0, 0, 3, 0);
    chk(mdl[3] == 8, "R3 model new mapping", mdl[3], 8);
    // R4: zero register rename and set
    do_op(2'b01, 0, 0, 0, 0);
    do_op(2'b10, 0, 12, 0, 0);
    do_op(2'b00, 0, 0, 0, 0);
    // R5: misc rename and set ignored
    do_op(2'b01, 21, 0, 21, 0);
    do_op(2'b10, 21, 5, 21, 0);
    do_op(2'b00, 0, 0, 21, 0);
    // R7: set-entry on fp and restore on int
    do_op(2'b10, 10, 30, 10, 0);
    do_op(2'b10, 3, 3, 10, 0);
    do_op(2'b00, 0, 0, 3, 0);
    do_op(2'b11, 5, 9, 5, 0);
    // R8: fp below int
    do_op(2'b01, 9, 0, 9, 0);
    do_op(2'b01, 11, 0, 9, 0);
    do_op(2'b01, 12, 0, 11, 0);
    // R6: drain condition-code list, then stall
    for (int k = 0; k < 4; k++) do_op(2'b01, 16 + k, 0, 16 + k, 0);
    do_op(2'b01, 17, 0, 17, 0);
    do_op(2'b00, 0, 0, 17, 0);
    // Random phase from fresh reset, recycling replaced registers
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int a, op, sp, c;
      op = $urandom % 4;
      a = $urandom % NARCH;
      c = bcls(a);
      sp = (c == 3) ? ($urandom % 40) : bbase(c) + ($urandom % bphys(c));
      do_op(2'(op), a, sp, $urandom % NARCH, 1);
    end
    @(negedge clk);
    op_code = 2'b00;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule